// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block sits between the register file and a 10-bit successive-approximation converter. It decides when the converter takes a sample. A 2-bit mode input picks one of four start sources: a software start bit, a baseband signal-strength request that fires after a programmable delay, a voice-path pacing tick, or an external timer trigger. The block sends the converter a single-cycle start pulse. It then waits for the converter's done strobe and takes in the raw sample.

Each raw sample is corrected by adding a signed DC offset, and the sum is clamped to the converter's code range. The block latches the corrected value together with the channel code that was selected when the start was accepted. It then sets a completion flag, which software clears by writing a one to a separate clear input. All configuration fields arrive as plain input ports.

The controller is a four-state machine:
- IDLE waits for a start from the selected source.
- DELAY counts down the signal-strength delay.
- LAUNCH drives the start pulse for one cycle.
- CONVERT waits for the done strobe.

The transitions are:
- IDLE to LAUNCH: a start is accepted with no delay.
- IDLE to DELAY: a signal-strength request arrives with a non-zero delay.
- DELAY to LAUNCH: the delay counter is exhausted.
- LAUNCH to CONVERT: always, after one cycle.
- CONVERT to IDLE: the done strobe arrives.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, conv_start, busy and done_flag are 0, and result and result_chan are 0.
- R2: With mode 2'b00, sw_start sampled high while idle makes conv_start high for exactly one cycle, starting the cycle after. busy is high from that cycle until the cycle after the done strobe. sw_start sampled while busy produces no start.
- R3: With mode 2'b01, rssi_req sampled high while idle makes conv_start rise rssi_delay cycles later than it would for a delay of 0. A delay of 0 starts in the next cycle, as in R2.
- R4: A request that arrives while the delay is counting, or while a conversion is in flight, is ignored. It produces no additional start pulse.
- R5: With mode 2'b10, voice_tick is the start source. With mode 2'b11, tmr_trig is the start source. Inputs belonging to the other modes start nothing.
- R6: When conv_done is sampled high in CONVERT, result takes the value raw + dc_offset in the following cycle. raw is conv_data, read as unsigned. dc_offset is read as signed two's complement. The sum is clamped to the range 0 to 1023.
- R7: result_chan reports the chan_sel value sampled in the cycle the start was accepted.
- R8: done_flag goes high in the cycle after a completion. flag_clr sampled high clears it in the following cycle.
- R9: If flag_clr is high in the same cycle as a completion, done_flag ends up set.
- R10: conv_done sampled while not in CONVERT is ignored: result and done_flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Start source: 00 software, 01 signal strength, 10 voice, 11 timer |
| sw_start | input | 1 | Software start bit |
| rssi_req | input | 1 | Baseband signal-strength request |
| rssi_delay | input | 6 | Delay, in clock cycles, from request to start |
| voice_tick | input | 1 | Voice-path pacing request |
| tmr_trig | input | 1 | External timer trigger |
| chan_sel | input | 4 | Channel code in use |
| dc_offset | input | 10 | Signed correction added to each sample |
| flag_clr | input | 1 | Clear for the completion flag |
| conv_done | input | 1 | Done strobe from the converter |
| conv_data | input | 10 | Raw sample from the converter |
| conv_start | output | 1 | Start pulse to the converter |
| busy | output | 1 | A request has been accepted and its result is not yet stored |
| result | output | 10 | Corrected, clamped sample |
| result_chan | output | 4 | Channel code of the stored result |
| done_flag | output | 1 | Completion flag |

## Verification
A state machine stuck outside IDLE shows up within one cycle of the next request as a missing start pulse, with busy held high. A machine that re-enters LAUNCH shows up as a second start pulse one cycle after the first. A wrong delay count moves the start edge by whole cycles, so the bench measures the latency of every signal-strength request exactly. Faults in offset or clamp handling, and a stale channel register, appear in result and result_chan one cycle after the done strobe. The flag's set-over-clear priority and the handling of stray strobes are checked at done_flag on the cycle that follows.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DELAY   = 2'd1,
        ST_LAUNCH  = 2'd2,
        ST_CONVERT = 2'd3
    } trig_state_e;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'b00,
        SRC_RSSI  = 2'b01,
        SRC_VOICE = 2'b10,
        SRC_TIMER = 2'b11
    } trig_src_e;
endpackage

// File: rtl/adc_trig_src_sel.sv
module adc_trig_src_sel
    import adc_trig_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sw_start,
    input  logic       rssi_req,
    input  logic       voice_tick,
    input  logic       tmr_trig,
    output logic       trig,
    output logic       trig_delayed
);
    always_comb begin
        trig         = 1'b0;
        trig_delayed = 1'b0;
        unique case (trig_src_e'(mode))
            SRC_SOFT:  trig = sw_start;
            SRC_RSSI: begin
                trig         = rssi_req;
                trig_delayed = 1'b1;
            end
            SRC_VOICE: trig = voice_tick;
            SRC_TIMER: trig = tmr_trig;
            default:   trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_trig_delay.sv
module adc_trig_delay #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_trig_offset.sv
module adc_trig_offset #(
    parameter int DATA_W = 10
) (
    input  logic        [DATA_W-1:0] raw,
    input  logic signed [DATA_W-1:0] offset,
    output logic        [DATA_W-1:0] corrected
);
    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << DATA_W) - 1);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, raw}) + SUM_W'(offset);
        if (sum < 0)
            corrected = '0;
        else if (sum > CODE_MAX)
            corrected = CODE_MAX[DATA_W-1:0];
        else
            corrected = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CHAN_W = 4,
    parameter int DLY_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode,
    input  logic                     sw_start,
    input  logic                     rssi_req,
    input  logic [DLY_W-1:0]         rssi_delay,
    input  logic                     voice_tick,
    input  logic                     tmr_trig,
    input  logic [CHAN_W-1:0]        chan_sel,
    input  logic signed [DATA_W-1:0] dc_offset,
    input  logic                     flag_clr,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic                     conv_start,
    output logic                     busy,
    output logic [DATA_W-1:0]        result,
    output logic [CHAN_W-1:0]        result_chan,
    output logic                     done_flag
);
    trig_state_e state_q, state_d;

    logic              trig, trig_delayed;
    logic              dly_load, dly_expired;
    logic              accept, completion;
    logic [DATA_W-1:0] corrected;
    logic [CHAN_W-1:0] pend_chan_q;

    adc_trig_src_sel u_src (
        .mode         (mode),
        .sw_start     (sw_start),
        .rssi_req     (rssi_req),
        .voice_tick   (voice_tick),
        .tmr_trig     (tmr_trig),
        .trig         (trig),
        .trig_delayed (trig_delayed)
    );

    assign accept     = (state_q == ST_IDLE) && trig;
    assign dly_load   = accept && trig_delayed && (rssi_delay != '0);
    assign completion = (state_q == ST_CONVERT) && conv_done;

    adc_trig_delay #(.DLY_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (rssi_delay - 1'b1),
        .run      (state_q == ST_DELAY),
        .expired  (dly_expired)
    );

    adc_trig_offset #(.DATA_W(DATA_W)) u_ofs (
        .raw       (conv_data),
        .offset    (dc_offset),
        .corrected (corrected)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dly_load)
                    state_d = ST_DELAY;
                else if (accept)
                    state_d = ST_LAUNCH;
            end
            ST_DELAY:   if (dly_expired) state_d = ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_CONVERT;
            ST_CONVERT: if (conv_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_chan_q <= '0;
            result      <= '0;
            result_chan <= '0;
            done_flag   <= 1'b0;
        end else begin
            if (accept)
                pend_chan_q <= chan_sel;
            if (completion) begin
                result      <= corrected;
                result_chan <= pend_chan_q;
                done_flag   <= 1'b1;
            end else if (flag_clr) begin
                done_flag   <= 1'b0;
            end
        end
    end

    assign conv_start = (state_q == ST_LAUNCH);
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk
    import adc_trig_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        conv_start,
    input logic        busy,
    input logic        conv_done,
    input logic        flag_clr,
    input logic        done_flag,
    input trig_state_e state_q
);
    logic completion;
    assign completion = (state_q == ST_CONVERT) && conv_done;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy);

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        completion |=> done_flag);

    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !completion) |=> !done_flag);

    a_r10_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !flag_clr) |=> $stable(done_flag));
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .busy       (busy),
    .conv_done  (conv_done),
    .flag_clr   (flag_clr),
    .done_flag  (done_flag),
    .state_q    (state_q)
);

// File: tb/adc_trig_ctrl_test.sv
module adc_trig_ctrl_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              sw_start = 1'b0, rssi_req = 1'b0, voice_tick = 1'b0, tmr_trig = 1'b0;
    logic [5:0]        rssi_delay = '0;
    logic [3:0]        chan_sel = '0;
    logic [9:0]        dc_offset = '0;
    logic              flag_clr = 1'b0, conv_done = 1'b0;
    logic [9:0]        conv_data = '0;
    logic              conv_start, busy, done_flag;
    logic [9:0]        result;
    logic [3:0]        result_chan;

    int applied = 0;
    int misses  = 0;
    int starts  = 0;

    always #5 clk = ~clk;

    adc_trig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sw_start(sw_start),
        .rssi_req(rssi_req), .rssi_delay(rssi_delay), .voice_tick(voice_tick),
        .tmr_trig(tmr_trig), .chan_sel(chan_sel), .dc_offset(dc_offset),
        .flag_clr(flag_clr), .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .busy(busy), .result(result),
        .result_chan(result_chan), .done_flag(done_flag)
    );

    always @(negedge clk) if (conv_start) starts++;

    // raw, offset, channel, expected result
    localparam logic [33:0] VEC [8] = '{
        {10'd100,  10'd5,   4'd3,  10'd105},
        {10'd0,    10'h3F8, 4'd1,  10'd0},
        {10'd1020, 10'd7,   4'd15, 10'd1023},
        {10'd1023, 10'd7,   4'd9,  10'd1023},
        {10'd3,    10'h3FD, 4'd0,  10'd0},
        {10'd512,  10'h3FF, 4'd6,  10'd511},
        {10'd700,  10'h200, 4'd12, 10'd188},
        {10'd300,  10'h1FF, 4'd5,  10'd811}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        applied++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_conv(input logic [9:0] raw);
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = raw;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Raise one request input, return the number of negedges until conv_start is seen.
    task automatic fire(input int which, input int limit, output int lat);
        lat = 0;
        case (which)
            0: sw_start = 1'b1;
            1: rssi_req = 1'b1;
            2: voice_tick = 1'b1;
            default: tmr_trig = 1'b1;
        endcase
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (i == 1) begin
                sw_start = 1'b0; rssi_req = 1'b0; voice_tick = 1'b0; tmr_trig = 1'b0;
            end
            if (conv_start) begin
                lat = i;
                break;
            end
        end
    endtask

    initial begin
        #2_000_000;
        misses++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

    initial begin
        int lat;
        int s0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!conv_start && !busy && !done_flag, "R1 reset controls", {conv_start, busy, done_flag}, 0);
        check(result == 0 && result_chan == 0, "R1 reset data", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R7 table in software mode
        for (int v = 0; v < 8; v++) begin
            dc_offset = VEC[v][23:14];
            chan_sel  = VEC[v][13:10];
            fire(0, 4, lat);
            check(lat == 1, "R2 software start latency", lat, 1);
            chan_sel = ~VEC[v][13:10];
            finish_conv(VEC[v][33:24]);
            check(result == VEC[v][9:0], "R6 corrected result", result, VEC[v][9:0]);
            check(result_chan == VEC[v][13:10], "R7 channel", result_chan, VEC[v][13:10]);
            check(done_flag && !busy, "R8 flag set", done_flag, 1);
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
            check(!done_flag, "R8 flag cleared", done_flag, 0);
        end
        dc_offset = '0;

        // R2 single pulse, busy, start ignored while busy
        s0 = starts;
        fire(0, 4, lat);
        @(negedge clk);
        check(!conv_start && busy, "R2 one cycle pulse", conv_start, 0);
        sw_start = 1'b1;
        repeat (3) @(negedge clk);
        sw_start = 1'b0;
        check(starts == s0 + 1, "R2 start ignored while busy", starts - s0, 1);
        finish_conv(10'd10);
        @(negedge clk);
        check(starts == s0 + 1 && !busy, "R2 no late start", starts - s0, 1);

        // R3 signal-strength delays
        mode = 2'b01;
        for (int d = 0; d < 4; d++) begin
            rssi_delay = 6'(d * 5);
            fire(1, 100, lat);
            check(lat == d * 5 + 1, "R3 delayed start", lat, d * 5 + 1);
            finish_conv(10'd20);
        end

        // R4 request during delay ignored
        rssi_delay = 6'd10;
        s0 = starts;
        rssi_req = 1'b1;
        @(negedge clk);
        rssi_req = 1'b0;
        repeat (3) @(negedge clk);
        rssi_req = 1'b1;
        @(negedge clk);
        rssi_req = 1'b0;
        repeat (20) @(negedge clk);
        check(starts == s0 + 1, "R4 extra request ignored", starts - s0, 1);
        finish_conv(10'd30);
        @(negedge clk);

        // R5 other-mode sources ignored, own source works
        mode = 2'b00;
        s0 = starts;
        rssi_req = 1'b1; voice_tick = 1'b1; tmr_trig = 1'b1;
        repeat (3) @(negedge clk);
        rssi_req = 1'b0; voice_tick = 1'b0; tmr_trig = 1'b0;
        check(starts == s0 && !busy, "R5 foreign sources in software mode", starts - s0, 0);
        mode = 2'b11;
        sw_start = 1'b1; voice_tick = 1'b1;
        repeat (3) @(negedge clk);
        sw_start = 1'b0; voice_tick = 1'b0;
        check(starts == s0, "R5 foreign sources in timer mode", starts - s0, 0);
        fire(3, 4, lat);
        check(lat == 1, "R5 timer start", lat, 1);
        finish_conv(10'd40);
        mode = 2'b10;
        fire(2, 4, lat);
        check(lat == 1, "R5 voice start", lat, 1);
        finish_conv(10'd50);
        check(result == 10'd50, "R6 voice result", result, 50);

        // R9 clear coincident with completion
        mode = 2'b00;
        fire(0, 4, lat);
        @(negedge clk);
        conv_done = 1'b1; conv_data = 10'd77; flag_clr = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; flag_clr = 1'b0;
        check(done_flag, "R9 set wins over clear", done_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;

        // R10 stray done strobe
        conv_done = 1'b1; conv_data = 10'd999;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        check(result == 10'd77 && !done_flag, "R10 stray strobe ignored", result, 77);

        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end
endmodule